// File: doc/BRIEF.md
# Loosely Packed Instruction Expander

This block sits in the decode front end of a 32-bit RISC core whose code has been compressed by shrinking the ordinary register and immediate formats. The space saved in each shrunken word holds a 5-bit index into a small table of frequently used instructions. The table sits outside the block. The expander accepts one fetched word per cycle and restores the full-width primary instruction. For a register-format word it moves the fields back to their normal positions. For an immediate-format word it also widens the immediate with sign extension. The restored instruction is issued on the cycle after the word is accepted.

When the trailing index is nonzero, the block reads the table entry through its read port. It issues that entry on the following cycle and holds fetch for exactly that one cycle. Index zero names the empty slot, so nothing extra is issued. When the primary instruction is a branch that the front end has resolved as taken, the front end raises a flag with the word. The trailing table instruction is then dropped. Jump words and load-upper-immediate words are never compressed, so they pass through unchanged and carry no index.

Top module: `lp_expander`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `out_valid`, `out_second` and `fetch_stall` are 0.
- R2: The format is chosen by the opcode in bits [31:26]. Opcode 0 is the loose register format. Opcodes 2, 3 (jumps) and 15 (load upper immediate) are unpacked. Every other opcode is the loose immediate format.
- R3: A loose register word has op[31:26], a shared field[25:21], rt[20:16], rd[15:11], funct[10:5] and index[4:0]. It is rebuilt as {op, rs, rt, rd, shamt, funct}. When funct is 0, 2 or 3 (constant shifts), the shared field goes to shamt and rs is 0. For any other funct it goes to rs and shamt is 0.
- R4: A loose immediate word has op[31:26], rs[25:21], rt[20:16], imm[15:5] and index[4:0]. It is rebuilt as {op, rs, rt, imm16}, where imm16 is the 11-bit immediate sign-extended from its bit 10.
- R5: An unpacked word (opcode 2, 3 or 15) is issued bit for bit unchanged, and no second instruction follows it, whatever its low five bits hold.
- R6: A loose word whose index is 0 issues only its primary instruction and does not raise `fetch_stall`.
- R7: A loose word with a nonzero index, accepted without `taken`, puts that index on `irf_rd_idx`. On the cycle after the primary is issued, the block issues `irf_rd_data` with `out_second` = 1.
- R8: `fetch_stall` is high for exactly one cycle per second issue. A word presented while it is high is ignored.
- R9: A word accepted with `taken` = 1 issues its primary instruction only, with no stall and no second issue, even when its index is nonzero.
- R10: A word accepted in one cycle appears on `out_word` with `out_valid` = 1 in the next cycle. A cycle with `in_valid` = 0 and no pending second issue yields `out_valid` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A fetched word is presented |
| in_word | input | 32 | Fetched, possibly loosely packed, word |
| taken | input | 1 | The presented word is a branch resolved as taken |
| irf_rd_data | input | 32 | Table entry addressed by `irf_rd_idx` |
| irf_rd_idx | output | 5 | Table index being read, 0 when idle |
| fetch_stall | output | 1 | Fetch must hold; the presented word is not accepted |
| out_valid | output | 1 | An instruction is issued this cycle |
| out_word | output | 32 | Issued full-width instruction |
| out_second | output | 1 | The issued instruction came from the table |

## Verification
The bench builds the block with its default index width of 5 and short-immediate width of 11. This makes the whole table range reachable, from the empty slot through index 31. It also gives both signs of the 11-bit immediate, including the most negative value and the largest positive one. Words are sent back to back, so a fresh word lands in the stall cycle, and taken branches carry nonzero indexes. Every shift and non-shift function code path is driven and compared against a behavioural model.

// File: rtl/lp_pkg.sv
package lp_pkg;

    localparam int WORD_W  = 32;
    localparam int OPC_W   = 6;
    localparam int REG_W   = 5;
    localparam int FUNCT_W = 6;
    localparam int IMM_W   = 16;

    localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
    localparam logic [OPC_W-1:0] OPC_J    = 6'd2;
    localparam logic [OPC_W-1:0] OPC_JAL  = 6'd3;
    localparam logic [OPC_W-1:0] OPC_LUI  = 6'd15;

    localparam logic [FUNCT_W-1:0] FN_SLL = 6'd0;
    localparam logic [FUNCT_W-1:0] FN_SRL = 6'd2;
    localparam logic [FUNCT_W-1:0] FN_SRA = 6'd3;

    typedef enum logic [1:0] {
        FMT_REG = 2'd0,
        FMT_IMM = 2'd1,
        FMT_RAW = 2'd2
    } fmt_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              valid;
        logic              second;
    } issue_t;

    function automatic fmt_e classify(input logic [OPC_W-1:0] op);
        fmt_e f;
        if (op == OPC_REG)
            f = FMT_REG;
        else if (op == OPC_J || op == OPC_JAL || op == OPC_LUI)
            f = FMT_RAW;
        else
            f = FMT_IMM;
        return f;
    endfunction

    function automatic logic is_const_shift(input logic [FUNCT_W-1:0] fn);
        return (fn == FN_SLL) || (fn == FN_SRL) || (fn == FN_SRA);
    endfunction

endpackage

// File: rtl/lp_field_decoder.sv
module lp_field_decoder
    import lp_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int SIMM_W = 11
) (
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] full,
    output logic [IDX_W-1:0]  idx,
    output fmt_e              fmt
);
    localparam int OP_LO    = WORD_W - OPC_W;
    localparam int A_LO     = OP_LO - REG_W;
    localparam int B_LO     = A_LO - REG_W;
    localparam int RD_LO    = B_LO - REG_W;
    localparam int FN_LO    = IDX_W;
    localparam int IMM_LO   = IDX_W;
    localparam int EXT_W    = IMM_W - SIMM_W;

    logic [OPC_W-1:0]   op;
    logic [REG_W-1:0]   fa;
    logic [REG_W-1:0]   fb;
    logic [REG_W-1:0]   frd;
    logic [FUNCT_W-1:0] fn;
    logic [SIMM_W-1:0]  simm;
    logic [IMM_W-1:0]   imm_full;
    logic [REG_W-1:0]   rs_o;
    logic [REG_W-1:0]   sh_o;

    assign op   = word[WORD_W-1:OP_LO];
    assign fa   = word[OP_LO-1:A_LO];
    assign fb   = word[A_LO-1:B_LO];
    assign frd  = word[B_LO-1:RD_LO];
    assign fn   = word[FN_LO+FUNCT_W-1:FN_LO];
    assign simm = word[IMM_LO+SIMM_W-1:IMM_LO];
    assign fmt  = classify(op);

    assign imm_full = {{EXT_W{simm[SIMM_W-1]}}, simm};

    always_comb begin
        if (is_const_shift(fn)) begin
            rs_o = '0;
            sh_o = fa;
        end else begin
            rs_o = fa;
            sh_o = '0;
        end
    end

    always_comb begin
        case (fmt)
            FMT_REG: begin
                full = {op, rs_o, fb, frd, sh_o, fn};
                idx  = word[IDX_W-1:0];
            end
            FMT_IMM: begin
                full = {op, fa, fb, imm_full};
                idx  = word[IDX_W-1:0];
            end
            default: begin
                full = word;
                idx  = '0;
            end
        endcase
    end

endmodule

// File: rtl/lp_issue_ctrl.sv
module lp_issue_ctrl
    import lp_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              taken,
    input  logic [WORD_W-1:0] full,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] irf_rd_data,
    output logic [IDX_W-1:0]  irf_rd_idx,
    output logic              stall,
    output issue_t            issue
);
    logic [IDX_W-1:0] pend_q;
    logic             accept;

    assign stall      = (pend_q != '0);
    assign irf_rd_idx = pend_q;
    assign accept     = in_valid && !stall;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            issue  <= '0;
        end else if (stall) begin
            issue.valid  <= 1'b1;
            issue.second <= 1'b1;
            issue.word   <= irf_rd_data;
            pend_q       <= '0;
        end else begin
            issue.valid  <= accept;
            issue.second <= 1'b0;
            issue.word   <= accept ? full : '0;
            pend_q       <= (accept && !taken) ? idx : '0;
        end
    end

endmodule

// File: rtl/lp_expander.sv
module lp_expander
    import lp_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int SIMM_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              taken,
    input  logic [WORD_W-1:0] irf_rd_data,
    output logic [IDX_W-1:0]  irf_rd_idx,
    output logic              fetch_stall,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              out_second
);
    logic [WORD_W-1:0] dec_full;
    logic [IDX_W-1:0]  dec_idx;
    fmt_e              dec_fmt;
    issue_t            issue;

    lp_field_decoder #(.IDX_W(IDX_W), .SIMM_W(SIMM_W)) u_dec (
        .word (in_word),
        .full (dec_full),
        .idx  (dec_idx),
        .fmt  (dec_fmt)
    );

    lp_issue_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .taken       (taken),
        .full        (dec_full),
        .idx         (dec_idx),
        .irf_rd_data (irf_rd_data),
        .irf_rd_idx  (irf_rd_idx),
        .stall       (fetch_stall),
        .issue       (issue)
    );

    assign out_valid  = issue.valid;
    assign out_word   = issue.word;
    assign out_second = issue.second;

endmodule

// File: rtl/lp_expander_chk.sv
module lp_expander_chk
    import lp_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_word,
    input logic              taken,
    input logic [IDX_W-1:0]  irf_rd_idx,
    input logic              fetch_stall,
    input logic              out_valid,
    input logic              out_second
);
    // R8
    single_stall_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_stall |=> !fetch_stall);

    // R7
    second_follows_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_stall |=> (out_valid && out_second));

    // R7
    read_index_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_stall |-> (irf_rd_idx != '0));

    // R9
    taken_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && taken && !fetch_stall) |=> !fetch_stall);

    // R5
    raw_no_second_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !fetch_stall && classify(in_word[WORD_W-1:WORD_W-OPC_W]) == FMT_RAW)
        |=> !fetch_stall);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !fetch_stall) |=> !out_valid);

endmodule

bind lp_expander lp_expander_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_word     (in_word),
    .taken       (taken),
    .irf_rd_idx  (irf_rd_idx),
    .fetch_stall (fetch_stall),
    .out_valid   (out_valid),
    .out_second  (out_second)
);

// File: tb/lp_expander_bench.sv
module lp_expander_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        taken = 1'b0;
    logic [31:0] irf_rd_data;
    logic [4:0]  irf_rd_idx;
    logic        fetch_stall;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_second;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] irf_mem [32];
    string cur_tag = "R10";

    logic        m_valid;
    logic [31:0] m_word;
    logic        m_second;
    int          m_pend;
    string       m_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign irf_rd_data = irf_mem[irf_rd_idx];

    lp_expander u_lp_expander (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .taken(taken), .irf_rd_data(irf_rd_data), .irf_rd_idx(irf_rd_idx),
        .fetch_stall(fetch_stall), .out_valid(out_valid), .out_word(out_word),
        .out_second(out_second)
    );

    function automatic void ref_expand(input logic [31:0] w, output logic [31:0] e, output int ix);
        int op, a, b, d, fn, imm;
        op = int'(w >> 26);
        a  = int'((w >> 21) & 32'h1f);
        b  = int'((w >> 16) & 32'h1f);
        d  = int'((w >> 11) & 32'h1f);
        fn = int'((w >> 5) & 32'h3f);
        ix = int'(w & 32'h1f);
        if (op == 2 || op == 3 || op == 15) begin
            e  = w;
            ix = 0;
        end else if (op == 0) begin
            if (fn == 0 || fn == 2 || fn == 3)
                e = (b << 16) | (d << 11) | (a << 6) | fn;
            else
                e = (a << 21) | (b << 16) | (d << 11) | fn;
        end else begin
            imm = int'((w >> 5) & 32'h7ff);
            if (imm >= 1024) imm = imm - 2048;
            e = (op << 26) | (a << 21) | (b << 16) | (imm & 32'hffff);
        end
    endfunction

    always @(posedge clk) begin
        logic [31:0] e;
        int ix;
        if (rst) begin
            m_valid <= 0; m_word <= 0; m_second <= 0; m_pend <= 0; m_tag <= "R1";
        end else if (m_pend != 0) begin
            m_valid <= 1; m_second <= 1; m_word <= irf_mem[m_pend];
            m_pend <= 0; m_tag <= "R7 R8";
        end else if (in_valid) begin
            ref_expand(in_word, e, ix);
            m_valid <= 1; m_second <= 0; m_word <= e;
            m_pend <= taken ? 0 : ix; m_tag <= cur_tag;
        end else begin
            m_valid <= 0; m_second <= 0; m_word <= 0; m_tag <= "R10";
        end
    end

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(m_tag, "out_valid", {31'd0, out_valid}, {31'd0, m_valid});
            check(m_tag, "out_second", {31'd0, out_second}, {31'd0, m_second});
            check((m_pend != 0) ? "R8" : "R6", "fetch_stall", {31'd0, fetch_stall},
                  {31'd0, m_pend != 0});
            if (m_valid) check(m_tag, "out_word", out_word, m_word);
            if (m_pend != 0) check("R7", "irf_rd_idx", {27'd0, irf_rd_idx}, m_pend);
        end
    end

    task automatic send(input logic [31:0] w, input bit t, input string tag);
        @(negedge clk);
        in_valid = 1; in_word = w; taken = t; cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0; in_word = '0; taken = 0; cur_tag = "R10";
        end
    endtask

    function automatic logic [31:0] rw(int a, int b, int d, int fn, int ix);
        return (a << 21) | (b << 16) | (d << 11) | (fn << 5) | ix;
    endfunction

    function automatic logic [31:0] iw(int op, int a, int b, int imm, int ix);
        return (op << 26) | (a << 21) | (b << 16) | ((imm & 32'h7ff) << 5) | ix;
    endfunction

    initial begin
        for (int i = 0; i < 32; i++) irf_mem[i] = 32'hC0DE_0000 + i * 32'h0101;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 0 || fetch_stall !== 0 || out_second !== 0) begin
            failures++;
            $display("FAIL R1 reset outputs actual=%b%b%b expected=000", out_valid, fetch_stall, out_second);
        end
        rst = 0;
        @(negedge clk);
        checks++;
        if (out_valid !== 0 || fetch_stall !== 0) begin
            failures++;
            $display("FAIL R1 after reset actual=%b%b expected=00", out_valid, fetch_stall);
        end
        // R2/R3: register format, shift and non-shift functions, index zero (R6)
        send(rw(7, 3, 9, 0, 0), 0, "R3");
        send(rw(7, 3, 9, 2, 0), 0, "R3");
        send(rw(7, 3, 9, 3, 0), 0, "R3");
        send(rw(7, 3, 9, 33, 0), 0, "R3");
        send(rw(31, 31, 31, 4, 0), 0, "R3");
        send(rw(5, 6, 7, 42, 0), 0, "R6");
        idle(2);
        // R4: immediate sign extension boundaries
        send(iw(9, 3, 5, 1023, 0), 0, "R4");
        send(iw(9, 3, 5, -1024, 0), 0, "R4");
        send(iw(35, 29, 3, 8, 0), 0, "R4");
        send(iw(4, 5, 0, -1, 0), 0, "R4");
        send(iw(2'd1, 1, 2, 0, 0), 0, "R2");
        idle(1);
        // R5: unpacked words with nonzero low bits
        send(32'h0800_001F, 0, "R5");
        send(32'h0C12_3455, 0, "R5");
        send(32'h3C1F_ABCD, 0, "R5");
        idle(1);
        // R7/R8: second issue; back-to-back word lands in stall cycle and is ignored
        send(rw(3, 4, 5, 33, 1), 0, "R7");
        send(iw(8, 1, 2, 77, 9), 0, "R8");
        send(iw(8, 1, 2, -5, 31), 0, "R7");
        send(iw(13, 6, 7, 3, 0), 0, "R8");
        send(iw(13, 6, 7, 4, 0), 0, "R10");
        idle(2);
        // R9: taken branches with nonzero index
        send(iw(4, 5, 0, -8, 2), 1, "R9");
        send(iw(5, 5, 0, 12, 17), 1, "R9");
        send(rw(2, 3, 4, 8, 6), 1, "R9");
        idle(2);
        // mixed stream
        for (int k = 0; k < 40; k++) begin
            int op;
            op = (k * 7) % 20;
            if (op == 0) send(rw(k % 32, (k * 3) % 32, (k * 5) % 32, (k * 11) % 64, k % 3 == 0 ? k % 32 : 0), k % 5 == 0, "R3");
            else send(iw(op, k % 32, (k * 3) % 32, k * 97 - 1900, (k * 13) % 32), k % 4 == 0, "R4");
        end
        idle(4);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        done = 1;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule